// File: doc/BRIEF.md
# Sample-and-Hold Refresh Sequencer

This block shares one DAC among a bank of sample-and-hold output channels by refreshing the channels one after another in a fixed rotation. A slow refresh clock paces the rotation. The clock is either divided down from the system clock or taken from an external synchronising pin. While the refresh clock is low, the block presents one channel's code to the DAC and closes that channel's hold switches. When the clock rises, the switches open and the pointer moves on to the next channel.

Each channel keeps a working code. On every visit, the working code moves toward the channel's target register by no more than a fixed step. A large jump in a target is therefore spread over several rotations, which bounds the voltage step on the held output.

The clock-mode input can change at any time, but the new mode takes effect only when a strobe ends. The clock pin is not driven after reset. It starts carrying the internal clock only once the block has changed over from external mode back to internal mode.

The FSM has two states:
- `ST_HOLD`: all switches are open.
- `ST_REFRESH`: one strobe is active.

It has two transitions:
- *enter_ref* (`ST_HOLD` to `ST_REFRESH`) is taken when the selected refresh clock is seen low.
- *leave_ref* (`ST_REFRESH` to `ST_HOLD`) is taken when that clock is seen high.

Top module: `sh_refresh_seq`

## Requirements
- R1: After reset, `sw_strobe` is all zero, `dac_code` is 0 and `clk_pin_oe` is 0, and the first strobe of the rotation goes to channel 0.
- R2: At most one bit of `sw_strobe` is set at a time. A strobe asserts one system clock after the selected refresh clock is seen low (after synchronisation) and clears one system clock after that clock is seen high.
- R3: Strobes visit channels in ascending order from 0 to NCH-1 and then wrap to 0, so each channel is refreshed once every NCH refresh cycles.
- R4: When a strobe for channel i starts, `dac_code` shows that channel's new working code. The new working code is the target if the target lies within STEP of the old working code; otherwise it is the old code moved STEP toward the target. Channel i's target is `tgt_codes[i*CODE_W +: CODE_W]`.
- R5: `dac_code` changes only at the start of a strobe, and it holds its value between strobes.
- R6: In internal mode, the refresh clock (shown on `clk_pin_out`) starts high after reset and toggles every DIV_HALF system clocks.
- R7: While `mode_ext` is 1 the external pin clock paces the sequencer after a two-flop synchroniser; while it is 0 the pin clock is ignored. A change of `mode_ext` takes effect only when a strobe ends.
- R8: `clk_pin_oe` is 0 from reset and in external mode. It becomes 1 when a change from external mode to internal mode takes effect, and it only changes when a strobe ends.
- R9: After a target changes by no more than STEP, the new code reaches the DAC within 1 to 19 refresh cycles.
- R10: Reset sets every working code to 0, so the first visits after reset rise from 0 in steps of STEP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ext | input | 1 | 1 selects the external refresh clock, 0 selects the internal one |
| ext_clk_in | input | 1 | External synchronising clock |
| tgt_codes | input | NCH*CODE_W | Per-channel target codes, packed with channel i in slice i |
| dac_code | output | CODE_W | Code presented to the shared DAC |
| sw_strobe | output | NCH | One-hot hold-switch strobe |
| clk_pin_out | output | 1 | Internal refresh clock, driven toward the clock pin |
| clk_pin_oe | output | 1 | Output enable for the clock pin |

## Verification
Four properties are checked on every cycle:
- `sw_strobe` is one-hot or zero.
- Each new strobe is the rotation of the previous one, starting from channel 0.
- The DAC code holds steady while a strobe is active.
- The clock-pin enable changes only as a strobe ends.

Some behaviours need the bench's scenarios and its per-cycle reference model to show them:
- the stepped approach of codes to their targets from the reset value of zero;
- the refresh latency after a target change;
- the divider period;
- the change of pacing when external mode takes over.

// File: rtl/sh_pkg.sv
package sh_pkg;
    typedef enum logic {
        ST_HOLD    = 1'b0,
        ST_REFRESH = 1'b1
    } seq_state_t;
endpackage

// File: rtl/sh_refclk_div.sv
module sh_refclk_div #(
    parameter int DIV_HALF = 1190
) (
    input  logic clk,
    input  logic rst_n,
    output logic lvl
);
    localparam int CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_HALF - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lvl   <= 1'b1;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
            lvl   <= ~lvl;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sh_sync2.sv
module sh_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic s1_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            q    <= 1'b1;
        end else begin
            s1_q <= d;
            q    <= s1_q;
        end
    end
endmodule

// File: rtl/sh_code_step.sv
module sh_code_step #(
    parameter int CODE_W = 11,
    parameter int STEP   = 372
) (
    input  logic [CODE_W-1:0] cur,
    input  logic [CODE_W-1:0] tgt,
    output logic [CODE_W-1:0] nxt
);
    localparam logic [CODE_W-1:0] STEP_C = CODE_W'(STEP);

    always_comb begin
        if (tgt > cur) begin
            nxt = ((tgt - cur) > STEP_C) ? cur + STEP_C : tgt;
        end else begin
            nxt = ((cur - tgt) > STEP_C) ? cur - STEP_C : tgt;
        end
    end
endmodule

// File: rtl/sh_refresh_seq.sv
module sh_refresh_seq #(
    parameter int NCH      = 18,
    parameter int CODE_W   = 11,
    parameter int DIV_HALF = 1190,
    parameter int STEP     = 372
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_ext,
    input  logic                  ext_clk_in,
    input  logic [NCH*CODE_W-1:0] tgt_codes,
    output logic [CODE_W-1:0]     dac_code,
    output logic [NCH-1:0]        sw_strobe,
    output logic                  clk_pin_out,
    output logic                  clk_pin_oe
);
    import sh_pkg::*;

    localparam int PTR_W = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NCH - 1);
    localparam logic [NCH-1:0]   ONE_HOT0 = {{(NCH-1){1'b0}}, 1'b1};

    seq_state_t        state_q, state_nx;
    logic              int_lvl, ext_lvl, ref_lvl;
    logic              src_ext_q, drv_en_q;
    logic [PTR_W-1:0]  ptr_q;
    logic [CODE_W-1:0] work_q [NCH];
    logic [CODE_W-1:0] tgt_arr [NCH];
    logic [CODE_W-1:0] step_nxt;
    logic              enter_ref, leave_ref;

    for (genvar g = 0; g < NCH; g++) begin : g_unpack
        assign tgt_arr[g] = tgt_codes[g*CODE_W +: CODE_W];
    end

    sh_refclk_div #(.DIV_HALF(DIV_HALF)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (int_lvl)
    );

    sh_sync2 u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ext_clk_in),
        .q     (ext_lvl)
    );

    sh_code_step #(.CODE_W(CODE_W), .STEP(STEP)) u_step (
        .cur (work_q[ptr_q]),
        .tgt (tgt_arr[ptr_q]),
        .nxt (step_nxt)
    );

    assign ref_lvl = src_ext_q ? ext_lvl : int_lvl;

    // Next-state logic
    always_comb begin
        state_nx  = state_q;
        enter_ref = 1'b0;
        leave_ref = 1'b0;
        unique case (state_q)
            ST_HOLD: begin
                if (!ref_lvl) begin
                    state_nx  = ST_REFRESH;
                    enter_ref = 1'b1;
                end
            end
            ST_REFRESH: begin
                if (ref_lvl) begin
                    state_nx  = ST_HOLD;
                    leave_ref = 1'b1;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_nx;
    end

    // Outputs, pointer, working codes and mode changeover
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q     <= '0;
            dac_code  <= '0;
            sw_strobe <= '0;
            src_ext_q <= 1'b0;
            drv_en_q  <= 1'b0;
            for (int i = 0; i < NCH; i++) work_q[i] <= '0;
        end else if (enter_ref) begin
            work_q[ptr_q] <= step_nxt;
            dac_code      <= step_nxt;
            sw_strobe     <= ONE_HOT0 << ptr_q;
        end else if (leave_ref) begin
            sw_strobe <= '0;
            ptr_q     <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
            src_ext_q <= mode_ext;
            if (mode_ext)       drv_en_q <= 1'b0;
            else if (src_ext_q) drv_en_q <= 1'b1;
        end
    end

    assign clk_pin_out = int_lvl;
    assign clk_pin_oe  = drv_en_q & ~src_ext_q;
endmodule

// File: rtl/sh_refresh_seq_chk.sv
module sh_refresh_seq_chk #(
    parameter int NCH    = 18,
    parameter int CODE_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCH-1:0]    sw_strobe,
    input logic [CODE_W-1:0] dac_code,
    input logic              clk_pin_oe
);
    logic [NCH-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 last_q <= {1'b1, {(NCH-1){1'b0}}};
        else if (sw_strobe != '0)   last_q <= sw_strobe;
    end

    // R2
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sw_strobe));

    // R3
    strobe_rotation_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_strobe != '0 && $past(sw_strobe) == '0) |->
            (sw_strobe == {last_q[NCH-2:0], last_q[NCH-1]}));

    // R5
    dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_strobe != '0) |=> $stable(dac_code));

    // R8
    pin_oe_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk_pin_oe) |-> $fell(|sw_strobe));
endmodule

bind sh_refresh_seq sh_refresh_seq_chk #(.NCH(NCH), .CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_strobe  (sw_strobe),
    .dac_code   (dac_code),
    .clk_pin_oe (clk_pin_oe)
);

// File: tb/sh_refresh_seq_test.sv
`timescale 1ns/1ps
module sh_refresh_seq_test;
    localparam int NCH = 18, CW = 11, DH = 3, STP = 200, EXT_HALF = 5;

    logic clk = 1'b0, rst_n = 1'b0, mode_ext = 1'b0, ext_clk = 1'b1;
    logic [NCH*CW-1:0] tgt = '0;
    logic [CW-1:0] dac_code;
    logic [NCH-1:0] sw_strobe;
    logic clk_pin_out, clk_pin_oe;
    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    sh_refresh_seq #(.NCH(NCH), .CODE_W(CW), .DIV_HALF(DH), .STEP(STP)) uut (
        .clk(clk), .rst_n(rst_n), .mode_ext(mode_ext), .ext_clk_in(ext_clk),
        .tgt_codes(tgt), .dac_code(dac_code), .sw_strobe(sw_strobe),
        .clk_pin_out(clk_pin_out), .clk_pin_oe(clk_pin_oe));

    always #10 clk = ~clk;

    always begin
        repeat (EXT_HALF) @(negedge clk);
        ext_clk = ~ext_clk;
    end

    // Behavioural reference model
    int m_cnt, m_vis, m_ptr, m_dac;
    bit m_int, m_s1, m_s2, m_src, m_drv, m_on, lvl;
    int m_work[NCH];
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_int = 1; m_s1 = 1; m_s2 = 1; m_src = 0; m_drv = 0;
            m_on = 0; m_ptr = 0; m_vis = 0; m_dac = 0;
            foreach (m_work[i]) m_work[i] = 0;
        end else begin
            int t, w;
            lvl = m_src ? m_s2 : m_int;
            if (m_cnt == DH - 1) begin m_cnt = 0; m_int = !m_int; end
            else m_cnt++;
            m_s2 = m_s1; m_s1 = ext_clk;
            if (!m_on && !lvl) begin
                t = int'(tgt[m_ptr*CW +: CW]); w = m_work[m_ptr];
                if (t > w + STP) w = w + STP;
                else if (t < w - STP) w = w - STP;
                else w = t;
                m_work[m_ptr] = w; m_dac = w; m_vis = m_ptr; m_on = 1;
            end else if (m_on && lvl) begin
                m_on = 0; m_ptr = (m_ptr + 1) % NCH;
                if (mode_ext) m_drv = 0; else if (m_src) m_drv = 1;
                m_src = mode_ext;
            end
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) if (rst_n && !done) begin
        logic [NCH-1:0] es;
        es = m_on ? (NCH'(1) << m_vis) : '0;
        chk(sw_strobe === es, "R2,R3 strobe", int'(sw_strobe), int'(es));
        chk(dac_code === CW'(m_dac), "R4,R5,R10 dac", int'(dac_code), m_dac);
        chk(clk_pin_oe === (m_drv && !m_src), "R8 oe", int'(clk_pin_oe), int'(m_drv && !m_src));
        chk(clk_pin_out === m_int, "R6 pin", int'(clk_pin_out), int'(m_int));
    end

    task automatic wait_rise(output int idx);
        logic p;
        p = |sw_strobe;
        forever begin
            @(negedge clk);
            if ((|sw_strobe) && !p) break;
            p = |sw_strobe;
        end
        idx = -1;
        for (int i = 0; i < NCH; i++) if (sw_strobe[i]) idx = i;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            finish_run();
        end
    end

    initial begin
        int idx, n, exp;
        realtime t0;
        for (int i = 0; i < NCH; i++) tgt[i*CW +: CW] = CW'(1000);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(sw_strobe == '0, "R1 strobe", int'(sw_strobe), 0);
        chk(dac_code == '0, "R1 dac", int'(dac_code), 0);
        chk(clk_pin_oe == 1'b0, "R1 oe", int'(clk_pin_oe), 0);
        // R3/R10/R4: five rotations, codes rise from 0 in steps of 200
        for (int r = 1; r <= 5; r++) begin
            for (int c = 0; c < NCH; c++) begin
                wait_rise(idx);
                chk(idx == c, "R3 order", idx, c);
                exp = (STP * r > 1000) ? 1000 : STP * r;
                chk(int'(dac_code) == exp, "R10 step", int'(dac_code), exp);
            end
        end
        // R4 large drop on channel 3, later seen by the model
        tgt[3*CW +: CW] = CW'(100);
        // R9 latency of a small change on channel 5
        tgt[5*CW +: CW] = CW'(1050);
        n = 0;
        do begin wait_rise(idx); n++; end while (idx != 5);
        chk(n >= 1 && n <= 19, "R9 latency", n, 19);
        chk(int'(dac_code) == 1050, "R9 code", int'(dac_code), 1050);
        // R6 divider period
        @(clk_pin_out); @(negedge clk); t0 = $realtime;
        @(clk_pin_out); @(negedge clk);
        n = int'(($realtime - t0) / 20.0);
        chk(n == DH, "R6 period", n, DH);
        // R7 external mode paces strobes
        mode_ext = 1'b1;
        repeat (3) wait_rise(idx);
        t0 = $realtime;
        wait_rise(idx);
        n = int'(($realtime - t0) / 20.0);
        chk(n == 2 * EXT_HALF, "R7 ext pacing", n, 2 * EXT_HALF);
        chk(clk_pin_oe == 1'b0, "R8 oe ext", int'(clk_pin_oe), 0);
        // R8 return to internal mode drives the pin
        mode_ext = 1'b0;
        repeat (3) wait_rise(idx);
        chk(clk_pin_oe == 1'b1, "R8 oe internal", int'(clk_pin_oe), 1);
        t0 = $realtime;
        wait_rise(idx);
        n = int'(($realtime - t0) / 20.0);
        chk(n == 2 * DH, "R7 internal pacing", n, 2 * DH);
        repeat (40) wait_rise(idx);
        finish_run();
    end
endmodule